// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block forms the outbound cell stream of an ATM transmit path. It runs a continuous 53-octet cell rhythm and hands one octet per clock to the downstream framer. At every cell boundary it picks what goes out next. A requested maintenance cell from a one-cell local buffer goes first. If there is none, a complete user cell waiting in the transmit FIFO goes next. Otherwise a programmable idle cell fills the slot.

Octets are changed on their way out. The fifth octet of each user cell carries an integrity pattern, which is compared against a configured value. That octet can be replaced by a freshly computed header check byte. The 48 payload octets can be scrambled. The top nibble of the first octet can be overwritten with a flow-control value that an external source shifts in serially. The block supplies the bit strobe for that source.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: The output carries one octet every cycle in cells of 53 octets. `tx_soc` is high only with octet 1, `tx_cell_done` is high only with octet 53, and the next `tx_soc` follows directly after `tx_cell_done`.
- R2: At a cell boundary the source is picked in this order: a pending maintenance cell, then a FIFO cell (only when `fifo_cell_avail` is high), then an idle cell. A FIFO holding less than a whole cell yields an idle cell.
- R3: A FIFO cell is read with 53 consecutive `fifo_rd` cycles, one per octet. With all options off, its octets appear on `tx_data` unchanged and in order.
- R4: The fifth octet of a FIFO cell is compared with `cfg_chk_pattern`. On a mismatch, `chk_err` is high for exactly the cycle in which that octet is on `tx_data`, and the cell is still sent.
- R5: With `cfg_hec_en` high, octet 5 becomes the CRC-8 (generator x^8+x^2+x+1, initial value zero, MSB first) over outbound octets 1 to 4, XORed with 0x55. With it low, octet 5 of FIFO and maintenance cells passes unchanged.
- R6: An idle cell sends `cfg_idle_hdr[31:24]` as octet 1 down to `cfg_idle_hdr[7:0]` as octet 4. Its octet 5 is always the check byte of R5. Its 48 payload octets equal `cfg_idle_fill`.
- R7: A pulse on `oam_wr` stores `oam_wdata` at `oam_addr` (address 0 is octet 1). A one-cycle `oam_send` makes the stored cell go out exactly once, at the next cell boundary.
- R8: With `cfg_scr_en` high, octets 6 to 53 are scrambled MSB first as y(n) = x(n) XOR y(n-43). Scrambler history carries from cell to cell, and octets 1 to 5 are never scrambled.
- R9: `gfc_clk` is high for four cycles, while `tx_data` carries octets 48 to 51, and `gfc_msb` is high on the first of them. `gfc_in` is sampled at each rising clock edge while `gfc_clk` is high, most significant bit first. With `cfg_gfc_en` high, the next cell's octet 1 bits 7:4 are replaced by these bits, and the check byte covers the replaced octet.
- R10: While `rst_n` is low, `tx_data` is zero and `tx_soc`, `tx_cell_done`, `chk_err`, `fifo_rd`, `gfc_clk` and `gfc_msb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_cell_avail | input | 1 | FIFO holds at least one complete cell |
| fifo_data | input | 8 | Octet at the FIFO head |
| fifo_rd | output | 1 | Pops the FIFO head at this clock edge |
| cfg_hec_en | input | 1 | Insert computed check byte into octet 5 |
| cfg_scr_en | input | 1 | Scramble payload octets |
| cfg_gfc_en | input | 1 | Replace flow-control nibble from the serial input |
| cfg_chk_pattern | input | 8 | Expected octet 5 of FIFO cells |
| cfg_idle_hdr | input | 32 | Idle cell header, octet 1 in the top byte |
| cfg_idle_fill | input | 8 | Idle cell payload octet |
| oam_wr | input | 1 | Write strobe for the maintenance cell buffer |
| oam_addr | input | 6 | Buffer octet index, 0 to 52 |
| oam_wdata | input | 8 | Buffer write data |
| oam_send | input | 1 | Request one transmission of the buffer |
| gfc_clk | output | 1 | Serial flow-control bit strobe |
| gfc_msb | output | 1 | Marks the most significant flow-control bit |
| gfc_in | input | 1 | Serial flow-control data |
| tx_data | output | 8 | Outbound octet |
| tx_soc | output | 1 | Octet 1 of a cell is on `tx_data` |
| tx_cell_done | output | 1 | Octet 53 of a cell is on `tx_data` |
| chk_err | output | 1 | Integrity pattern mismatch in the current cell |

## Verification
The checker assumes that the FIFO raises `fifo_cell_avail` only when 53 octets are really present, and that the head octet is valid whenever `fifo_rd` is high. The bench's FIFO model keeps to this by computing the flag from its own fill level. It also assumes that the maintenance buffer is not rewritten while its cell is being sent. The bench loads the buffer only while idle or FIFO cells go out. Configuration changes and pushes are made just after a `tx_soc`, so every cell that is compared was formed under one stable setting.

// File: rtl/atm_txcp_pkg.sv
package atm_txcp_pkg;

   typedef enum logic [1:0] {
      SRC_IDLE = 2'd0,
      SRC_FIFO = 2'd1,
      SRC_OAM  = 2'd2
   } txcp_src_e;

   // One octet of CRC-8, generator x^8+x^2+x+1, octet folded in before the shifts.
   function automatic logic [7:0] crc8_octet(input logic [7:0] acc, input logic [7:0] octet);
      logic [7:0] r;
      r = acc ^ octet;
      for (int i = 0; i < 8; i++) begin
         r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
      end
      return r;
   endfunction

endpackage

// File: rtl/atm_txcp_hec.sv
module atm_txcp_hec #(
   parameter logic [7:0] COSET = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       first,
   input  logic       step,
   input  logic [7:0] din,
   output logic [7:0] hec_byte
);
   import atm_txcp_pkg::*;

   logic [7:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= 8'h00;
      end else if (step) begin
         acc_q <= crc8_octet(first ? 8'h00 : acc_q, din);
      end
   end

   assign hec_byte = acc_q ^ COSET;

endmodule

// File: rtl/atm_txcp_scr.sv
module atm_txcp_scr #(
   parameter int LAG = 43
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [7:0] din,
   output logic [7:0] dout
);
   if (LAG < 9) begin : g_bad_lag
      $error("atm_txcp_scr: LAG must be at least 9");
   end

   logic [LAG-1:0] hist_q;
   logic [LAG-1:0] hist_n;

   always_comb begin
      logic o;
      hist_n = hist_q;
      dout   = '0;
      for (int i = 7; i >= 0; i--) begin
         o       = din[i] ^ hist_n[LAG-1];
         dout[i] = o;
         hist_n  = {hist_n[LAG-2:0], o};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (en) begin
         hist_q <= hist_n;
      end
   end

endmodule

// File: rtl/atm_txcp_oam_buf.sv
module atm_txcp_oam_buf #(
   parameter int CELL_LEN = 53,
   parameter int AW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [CELL_LEN*8-1:0] flat;

   for (genvar g = 0; g < CELL_LEN; g++) begin : g_ent
      logic [7:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= 8'h00;
         end else if (wr && (waddr == AW'(g))) begin
            ent_q <= wdata;
         end
      end
      assign flat[g*8 +: 8] = ent_q;
   end

   always_comb begin
      rdata = 8'h00;
      if (int'(raddr) < CELL_LEN) begin
         rdata = flat[int'(raddr)*8 +: 8];
      end
   end

endmodule

// File: rtl/atm_txcp_gfc.sv
module atm_txcp_gfc #(
   parameter int GFC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win,
   input  logic             sin,
   output logic [GFC_W-1:0] val
);
   logic [GFC_W-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (win) begin
         sr_q <= {sr_q[GFC_W-2:0], sin};
      end
   end

   assign val = sr_q;

endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc #(
   parameter int         CELL_LEN    = 53,
   parameter int         HDR_LEN     = 5,
   parameter int         GFC_W       = 4,
   parameter int         SCR_LAG     = 43,
   parameter bit         SCR_PRESENT = 1'b1,
   parameter logic [7:0] HEC_COSET   = 8'h55,
   localparam int        CW          = $clog2(CELL_LEN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fifo_cell_avail,
   input  logic [7:0]               fifo_data,
   output logic                     fifo_rd,
   input  logic                     cfg_hec_en,
   input  logic                     cfg_scr_en,
   input  logic                     cfg_gfc_en,
   input  logic [7:0]               cfg_chk_pattern,
   input  logic [8*(HDR_LEN-1)-1:0] cfg_idle_hdr,
   input  logic [7:0]               cfg_idle_fill,
   input  logic                     oam_wr,
   input  logic [CW-1:0]            oam_addr,
   input  logic [7:0]               oam_wdata,
   input  logic                     oam_send,
   output logic                     gfc_clk,
   output logic                     gfc_msb,
   input  logic                     gfc_in,
   output logic [7:0]               tx_data,
   output logic                     tx_soc,
   output logic                     tx_cell_done,
   output logic                     chk_err
);
   import atm_txcp_pkg::*;

   localparam int LAST      = CELL_LEN - 1;
   localparam int HEC_IDX   = HDR_LEN - 1;
   localparam int GFC_FIRST = CELL_LEN - 1 - GFC_W;
   localparam int GFC_LASTI = CELL_LEN - 2;

   if (HDR_LEN < 2) begin : g_bad_hdr
      $error("atm_tx_cell_proc: HDR_LEN must be at least 2");
   end
   if (GFC_W < 2 || GFC_W > 7) begin : g_bad_gfc
      $error("atm_tx_cell_proc: GFC_W must lie in 2..7");
   end
   if (GFC_FIRST <= HDR_LEN) begin : g_bad_cell
      $error("atm_tx_cell_proc: CELL_LEN too short for header and flow-control window");
   end

   logic [CW-1:0]    cnt_q;
   logic             at_start;
   txcp_src_e        src_q;
   txcp_src_e        src_cur;
   txcp_src_e        src_new;
   logic             oam_pend_q;
   logic [7:0]       oam_rdata;
   logic [7:0]       idle_byte;
   logic [7:0]       raw_byte;
   logic [7:0]       hdr_byte;
   logic [7:0]       hec_byte;
   logic [7:0]       scr_byte;
   logic [7:0]       out_byte;
   logic [GFC_W-1:0] gfc_val;
   logic             in_payload;
   logic             scr_step;
   logic             use_hec;
   logic             chk_mis;
   logic             gfc_win;

   // Cell position counter
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(LAST)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_start   = (cnt_q == '0);
   assign in_payload = (cnt_q > CW'(HEC_IDX));

   // Source arbitration: maintenance cell, then FIFO cell, then idle
   always_comb begin
      if (oam_pend_q) begin
         src_new = SRC_OAM;
      end else if (fifo_cell_avail) begin
         src_new = SRC_FIFO;
      end else begin
         src_new = SRC_IDLE;
      end
   end

   assign src_cur = at_start ? src_new : src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q      <= SRC_IDLE;
         oam_pend_q <= 1'b0;
      end else begin
         src_q      <= src_cur;
         oam_pend_q <= (oam_pend_q && !at_start) || oam_send;
      end
   end

   assign fifo_rd = rst_n && (src_cur == SRC_FIFO);

   atm_txcp_oam_buf #(
      .CELL_LEN (CELL_LEN),
      .AW       (CW)
   ) u_oam (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (oam_wr),
      .waddr (oam_addr),
      .wdata (oam_wdata),
      .raddr (cnt_q),
      .rdata (oam_rdata)
   );

   // Idle cell octets
   always_comb begin
      int k;
      k = int'(cnt_q);
      if (k < HEC_IDX) begin
         idle_byte = cfg_idle_hdr[(HEC_IDX-1-k)*8 +: 8];
      end else if (k == HEC_IDX) begin
         idle_byte = 8'h00;
      end else begin
         idle_byte = cfg_idle_fill;
      end
   end

   always_comb begin
      case (src_cur)
         SRC_FIFO: raw_byte = fifo_data;
         SRC_OAM:  raw_byte = oam_rdata;
         default:  raw_byte = idle_byte;
      endcase
   end

   // Serial flow-control capture
   assign gfc_win = (cnt_q >= CW'(GFC_FIRST)) && (cnt_q <= CW'(GFC_LASTI));
   assign gfc_clk = rst_n && gfc_win;
   assign gfc_msb = rst_n && (cnt_q == CW'(GFC_FIRST));

   atm_txcp_gfc #(
      .GFC_W (GFC_W)
   ) u_gfc (
      .clk   (clk),
      .rst_n (rst_n),
      .win   (gfc_win),
      .sin   (gfc_in),
      .val   (gfc_val)
   );

   always_comb begin
      hdr_byte = raw_byte;
      if (at_start && cfg_gfc_en) begin
         hdr_byte = {gfc_val, raw_byte[7-GFC_W:0]};
      end
   end

   atm_txcp_hec #(
      .COSET (HEC_COSET)
   ) u_hec (
      .clk      (clk),
      .rst_n    (rst_n),
      .first    (at_start),
      .step     (cnt_q < CW'(HEC_IDX)),
      .din      (hdr_byte),
      .hec_byte (hec_byte)
   );

   assign scr_step = in_payload && cfg_scr_en;

   if (SCR_PRESENT) begin : g_scr
      atm_txcp_scr #(
         .LAG (SCR_LAG)
      ) u_scr (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (scr_step),
         .din   (hdr_byte),
         .dout  (scr_byte)
      );
   end else begin : g_no_scr
      assign scr_byte = hdr_byte;
   end

   assign use_hec = cfg_hec_en || (src_cur == SRC_IDLE);
   assign chk_mis = (src_cur == SRC_FIFO) && (cnt_q == CW'(HEC_IDX))
                    && (fifo_data != cfg_chk_pattern);

   always_comb begin
      if (cnt_q == CW'(HEC_IDX)) begin
         out_byte = use_hec ? hec_byte : hdr_byte;
      end else if (scr_step) begin
         out_byte = scr_byte;
      end else begin
         out_byte = hdr_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_data      <= 8'h00;
         tx_soc       <= 1'b0;
         tx_cell_done <= 1'b0;
         chk_err      <= 1'b0;
      end else begin
         tx_data      <= out_byte;
         tx_soc       <= at_start;
         tx_cell_done <= (cnt_q == CW'(LAST));
         chk_err      <= chk_mis;
      end
   end

endmodule

// File: rtl/atm_txcp_chk.sv
module atm_txcp_chk #(
   parameter int  CELL_LEN = 53,
   parameter int  HDR_LEN  = 5,
   localparam int CW       = $clog2(CELL_LEN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] cnt,
   input logic          fifo_rd,
   input logic          fifo_cell_avail,
   input logic          oam_pend,
   input logic          tx_soc,
   input logic          tx_cell_done,
   input logic          chk_err,
   input logic          gfc_clk,
   input logic          gfc_msb
);
   localparam int LAST = CELL_LEN - 1;

   p_done_then_soc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cell_done |=> tx_soc);

   p_soc_not_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_soc |-> !tx_cell_done);

   p_full_cell_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && fifo_rd) |-> fifo_cell_avail);

   p_oam_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && oam_pend) |-> !fifo_rd);

   p_read_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rd && cnt != CW'(LAST)) |=> fifo_rd);

   p_err_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chk_err |-> (cnt == CW'(HDR_LEN)));

   p_msb_in_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gfc_msb |-> gfc_clk);

   p_msb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gfc_msb |=> (gfc_clk && !gfc_msb));

endmodule

bind atm_tx_cell_proc atm_txcp_chk #(
   .CELL_LEN (CELL_LEN),
   .HDR_LEN  (HDR_LEN)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cnt             (cnt_q),
   .fifo_rd         (fifo_rd),
   .fifo_cell_avail (fifo_cell_avail),
   .oam_pend        (oam_pend_q),
   .tx_soc          (tx_soc),
   .tx_cell_done    (tx_cell_done),
   .chk_err         (chk_err),
   .gfc_clk         (gfc_clk),
   .gfc_msb         (gfc_msb)
);

// File: tb/atm_tx_cell_proc_test.sv
module atm_tx_cell_proc_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_cell_avail;
   logic [7:0]  fifo_data;
   logic        fifo_rd;
   logic        cfg_hec_en = 1'b0;
   logic        cfg_scr_en = 1'b0;
   logic        cfg_gfc_en = 1'b0;
   logic [7:0]  cfg_chk_pattern = 8'hC3;
   logic [31:0] cfg_idle_hdr = 32'h0000_0001;
   logic [7:0]  cfg_idle_fill = 8'h6A;
   logic        oam_wr = 1'b0;
   logic [5:0]  oam_addr = '0;
   logic [7:0]  oam_wdata = '0;
   logic        oam_send = 1'b0;
   logic        gfc_clk;
   logic        gfc_msb;
   logic        gfc_in = 1'b0;
   logic [7:0]  tx_data;
   logic        tx_soc;
   logic        tx_cell_done;
   logic        chk_err;

   always #5 clk = ~clk;

   atm_tx_cell_proc uut (
      .clk (clk), .rst_n (rst_n),
      .fifo_cell_avail (fifo_cell_avail), .fifo_data (fifo_data), .fifo_rd (fifo_rd),
      .cfg_hec_en (cfg_hec_en), .cfg_scr_en (cfg_scr_en), .cfg_gfc_en (cfg_gfc_en),
      .cfg_chk_pattern (cfg_chk_pattern), .cfg_idle_hdr (cfg_idle_hdr),
      .cfg_idle_fill (cfg_idle_fill),
      .oam_wr (oam_wr), .oam_addr (oam_addr), .oam_wdata (oam_wdata), .oam_send (oam_send),
      .gfc_clk (gfc_clk), .gfc_msb (gfc_msb), .gfc_in (gfc_in),
      .tx_data (tx_data), .tx_soc (tx_soc), .tx_cell_done (tx_cell_done), .chk_err (chk_err)
   );

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // FIFO model
   logic [7:0] fq [0:4095];
   int wp = 0;
   int rp = 0;
   logic rd_taken = 1'b0;
   assign fifo_cell_avail = (wp - rp) >= 53;
   assign fifo_data = fq[rp % 4096];
   always @(posedge clk) rd_taken <= fifo_rd;
   initial forever begin
      @(negedge clk);
      if (rd_taken) rp++;
   end

   // Serial flow-control source
   logic [3:0] gfc_word = 4'h0;
   int gidx = 0;
   initial forever begin
      @(negedge clk);
      if (gfc_clk) begin
         if (gfc_msb) gidx = 3;
         gfc_in = gfc_word[gidx];
         gidx--;
      end
   end

   logic [7:0] mk  [53];
   logic [7:0] ex  [53];
   logic [7:0] cap [53];
   logic [7:0] capa[53];
   logic       soc_at [53];
   logic       done_at[53];
   logic       err_at [53];

   function automatic logic [7:0] hec_ref(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c, input logic [7:0] d);
      logic [31:0] h;
      logic [7:0]  crc;
      logic        fb;
      h = {a, b, c, d};
      crc = 8'h00;
      for (int i = 31; i >= 0; i--) begin
         fb  = crc[7] ^ h[i];
         crc = {crc[6:0], 1'b0};
         if (fb) crc = crc ^ 8'h07;
      end
      return crc ^ 8'h55;
   endfunction

   task automatic build(input logic [31:0] hdr, input logic [7:0] o5, input logic [7:0] seed);
      for (int i = 0; i < 4; i++) mk[i] = hdr[31-8*i -: 8];
      mk[4] = o5;
      for (int i = 5; i < 53; i++) mk[i] = seed + 8'(i * 7);
      for (int i = 0; i < 53; i++) ex[i] = mk[i];
   endtask

   task automatic push_mk(input int n);
      for (int i = 0; i < n; i++) begin
         fq[wp % 4096] = mk[i];
         wp++;
      end
   endtask

   task automatic push_tail(input int from);
      for (int i = from; i < 53; i++) begin
         fq[wp % 4096] = mk[i];
         wp++;
      end
   endtask

   task automatic at_soc();
      do @(negedge clk); while (!tx_soc);
   endtask

   task automatic get_cell();
      do @(negedge clk); while (!tx_soc);
      for (int i = 0; i < 53; i++) begin
         if (i > 0) @(negedge clk);
         cap[i]     = tx_data;
         soc_at[i]  = tx_soc;
         done_at[i] = tx_cell_done;
         err_at[i]  = chk_err;
      end
   endtask

   task automatic cmp(input string req, input string what);
      int bad;
      bad = -1;
      for (int i = 0; i < 53; i++) if (cap[i] !== ex[i] && bad < 0) bad = i;
      chk(bad < 0, req, $sformatf("%s octet %0d", what, bad + 1),
          bad < 0 ? 0 : int'(cap[bad]), bad < 0 ? 0 : int'(ex[bad]));
   endtask

   task automatic framing(input string req);
      int ns, nd;
      ns = 0; nd = 0;
      for (int i = 1; i < 53; i++) ns += int'(soc_at[i]);
      for (int i = 0; i < 52; i++) nd += int'(done_at[i]);
      chk(soc_at[0] && ns == 0, req, "tx_soc only with octet 1", ns, 0);
      chk(done_at[52] && nd == 0, req, "tx_cell_done only with octet 53", nd, 0);
   endtask

   task automatic no_err(input string req);
      int n;
      n = 0;
      for (int i = 0; i < 53; i++) n += int'(err_at[i]);
      chk(n == 0, req, "chk_err count", n, 0);
   endtask

   task automatic idle_exp(input logic [31:0] hdr);
      for (int i = 0; i < 4; i++) ex[i] = hdr[31-8*i -: 8];
      ex[4] = hec_ref(ex[0], ex[1], ex[2], ex[3]);
      for (int i = 5; i < 53; i++) ex[i] = cfg_idle_fill;
   endtask

   // R10: reset state
   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(tx_data == 8'h00, "R10", "tx_data in reset", int'(tx_data), 0);
      chk(!tx_soc && !tx_cell_done && !chk_err, "R10", "flags in reset",
          int'({tx_soc, tx_cell_done, chk_err}), 0);
      chk(!fifo_rd && !gfc_clk && !gfc_msb, "R10", "strobes in reset",
          int'({fifo_rd, gfc_clk, gfc_msb}), 0);
      rst_n = 1'b1;
   endtask

   // R6, R1: idle cells when the FIFO is empty, back to back
   task automatic t_idle();
      at_soc();
      get_cell();
      idle_exp(cfg_idle_hdr);
      cmp("R6", "idle cell");
      framing("R1");
      get_cell();
      cmp("R6", "second idle cell");
      framing("R1");
   endtask

   // R3, R2: FIFO cell passed unchanged with options off
   task automatic t_fifo_pass();
      at_soc();
      build(32'h1234_5678, 8'hC3, 8'h11);
      push_mk(53);
      get_cell();
      cmp("R3", "fifo cell pass-through");
      no_err("R4");
      chk(wp == rp, "R3", "fifo octets consumed", rp, wp);
   endtask

   // R5: check byte inserted / passed
   task automatic t_hec();
      at_soc();
      cfg_hec_en = 1'b1;
      build(32'h0ABC_DEF0, 8'hC3, 8'h40);
      push_mk(53);
      ex[4] = hec_ref(ex[0], ex[1], ex[2], ex[3]);
      get_cell();
      cmp("R5", "check byte inserted");
      at_soc();
      cfg_hec_en = 1'b0;
      build(32'h0ABC_DEF0, 8'hC3, 8'h41);
      push_mk(53);
      get_cell();
      chk(cap[4] == 8'hC3, "R5", "octet 5 passed when disabled", int'(cap[4]), 8'hC3);
   endtask

   // R4: integrity mismatch flagged, cell still sent
   task automatic t_chk();
      int n;
      at_soc();
      cfg_hec_en = 1'b1;
      build(32'h0011_2233, 8'h00, 8'h90);
      push_mk(53);
      ex[4] = hec_ref(ex[0], ex[1], ex[2], ex[3]);
      get_cell();
      n = 0;
      for (int i = 0; i < 53; i++) n += int'(err_at[i]);
      chk(err_at[4] && n == 1, "R4", "chk_err once with octet 5", n, 1);
      cmp("R4", "mismatched cell still sent");
      cfg_hec_en = 1'b0;
   endtask

   // R2: partial FIFO content gives idle; completed cell then goes out
   task automatic t_partial();
      at_soc();
      build(32'h0F0E_0D0C, 8'hC3, 8'h22);
      push_mk(30);
      get_cell();
      idle_exp(cfg_idle_hdr);
      cmp("R2", "idle while fifo partial");
      at_soc();
      push_tail(30);
      build(32'h0F0E_0D0C, 8'hC3, 8'h22);
      get_cell();
      cmp("R2", "fifo cell after completion");
   endtask

   // R7, R2: maintenance cell first, exactly once
   task automatic t_oam();
      logic [7:0] ob [53];
      for (int i = 0; i < 53; i++) ob[i] = 8'hA0 ^ 8'(i * 3);
      for (int i = 0; i < 53; i++) begin
         @(negedge clk);
         oam_wr = 1'b1; oam_addr = 6'(i); oam_wdata = ob[i];
      end
      @(negedge clk);
      oam_wr = 1'b0;
      cfg_hec_en = 1'b1;
      at_soc();
      build(32'h0055_6677, 8'hC3, 8'h33);
      push_mk(53);
      oam_send = 1'b1;
      @(negedge clk);
      oam_send = 1'b0;
      get_cell();
      for (int i = 0; i < 53; i++) ex[i] = ob[i];
      ex[4] = hec_ref(ob[0], ob[1], ob[2], ob[3]);
      cmp("R7", "maintenance cell first");
      get_cell();
      build(32'h0055_6677, 8'hC3, 8'h33);
      ex[4] = hec_ref(ex[0], ex[1], ex[2], ex[3]);
      cmp("R2", "fifo cell after maintenance cell");
      get_cell();
      idle_exp(cfg_idle_hdr);
      cmp("R7", "maintenance cell not repeated");
      cfg_hec_en = 1'b0;
   endtask

   // R9: serial flow-control nibble
   task automatic t_gfc();
      at_soc();
      cfg_gfc_en = 1'b1;
      gfc_word = 4'hA;
      get_cell();
      idle_exp({4'hA, cfg_idle_hdr[27:0]});
      cmp("R9", "flow-control nibble in idle cell");
      at_soc();
      gfc_word = 4'h5;
      build(32'h0123_4567, 8'hC3, 8'h5C);
      push_mk(53);
      get_cell();
      ex[0] = {4'h5, mk[0][3:0]};
      chk(cap[0] == ex[0], "R9", "flow-control nibble in fifo cell", int'(cap[0]), int'(ex[0]));
      at_soc();
      cfg_gfc_en = 1'b0;
   endtask

   // R8: payload scrambling, verified by self-synchronising descrambling
   task automatic t_scr();
      logic [42:0] h;
      logic [7:0]  d;
      logic        y;
      int          bad, same;
      at_soc();
      cfg_scr_en = 1'b1;
      build(32'h0102_0304, 8'hC3, 8'h07);
      push_mk(53);
      build(32'h0506_0708, 8'hC3, 8'h99);
      push_mk(53);
      get_cell();
      for (int i = 0; i < 53; i++) capa[i] = cap[i];
      get_cell();
      h = '0;
      for (int i = 5; i < 53; i++)
         for (int b = 7; b >= 0; b--) h = {h[41:0], capa[i][b]};
      bad = -1; same = 0;
      for (int i = 5; i < 53; i++) begin
         for (int b = 7; b >= 0; b--) begin
            y = cap[i][b];
            d[b] = y ^ h[42];
            h = {h[41:0], y};
         end
         if (d !== ex[i] && bad < 0) bad = i;
         if (cap[i] == ex[i]) same++;
      end
      chk(bad < 0, "R8", "descrambled payload", bad, -1);
      chk(same < 10, "R8", "payload actually scrambled", same, 0);
      chk(cap[0] == ex[0] && cap[1] == ex[1] && cap[2] == ex[2] && cap[3] == ex[3]
          && cap[4] == ex[4], "R8", "header left clear", int'(cap[0]), int'(ex[0]));
      at_soc();
      cfg_scr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_idle();
      t_fifo_pass();
      t_hec();
      t_chk();
      t_partial();
      t_oam();
      t_gfc();
      t_scr();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule